// File: doc/BRIEF.md
# I2C Master Command Sequencer

This block is a single-master I2C controller driven by a host one operation at a time. The host can ask for a START, a repeated START, a STOP, a byte receive or a single acknowledge bit, and it starts a byte transmit by writing the transmit data. The block drives the open-drain SCL and SDA lines itself. Each line is driven low when its output enable is high and released otherwise. A programmable bit-rate divider sets the length of each SCL phase.

A bus monitor passes both lines through a two-flop synchroniser. It watches for START and STOP conditions and keeps a start-seen and a stop-seen status bit. A new START is only allowed when these bits show that the bus is free. Operations cannot be queued. A transmit write that arrives while anything is in progress is dropped and sets a sticky write-collision flag. A single sticky interrupt flag marks the end of every operation. After START, repeated START, a byte or an acknowledge bit, the sequencer keeps SCL low until the host issues the next operation.

Top module: `i2c_cmd_master`

## Requirements
- R1: After reset the block releases both lines (`scl_oe_o`=0, `sda_oe_o`=0) and shows `busy_o`, `irq_o`, `wcol_o`, `start_seen_o` and `stop_seen_o` all at 0.
- R2: Command code 1 (START) is taken only when the block is idle, enabled, not holding SCL, and the bus is free (stop-seen set, or both status bits clear). It pulls SDA low while SCL is released, then holds SCL low and sets `irq_o`. If the bus is not free, the command is ignored: `busy_o` stays 0 and `irq_o` is not set.
- R3: A write on `wr_buf_i` while the block is idle clears `ack_stat_o` and shifts out `wdata_i` MSB first, one bit per SCL high phase. SDA is released for a ninth clock. The SDA level seen on that ninth clock goes to `ack_stat_o` (0 means acknowledged), and `irq_o` is set.
- R4: Command code 4 (receive) gives eight SCL clocks with SDA released. It collects the bits MSB first into `rdata_o` and sets `irq_o`.
- R5: Command code 5 (acknowledge) gives one SCL clock. SDA is held low when `ack_bit_i`=0 and released when it is 1. Then `irq_o` is set.
- R6: Command code 3 (STOP) releases SDA while SCL is released, leaves both lines released and sets `irq_o`.
- R7: Command code 2 (repeated START), issued while SCL is held low, releases SDA and then SCL. It pulls SDA low while SCL is high, then holds SCL low and sets `irq_o`.
- R8: A START condition on the synchronised pins sets `start_seen_o` and clears `stop_seen_o`. A STOP condition does the opposite. The two bits are never both set, and both are cleared while `en_i` is low.
- R9: A `wr_buf_i` pulse while `busy_o`=1, or in the same cycle as `cmd_valid_i`, does not load data and sets `wcol_o`. `wcol_o` stays set until `wcol_clr_i` is pulsed, and `irq_o` stays set until `irq_clr_i` is pulsed. Commands issued while busy are ignored.
- R10: Between two bit clocks, every SCL low phase lasts `brg_reload_i`+1 clock cycles. A high phase does not start counting while another device holds SCL low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Block enable |
| brg_reload_i | input | 7 | Bit-rate divider reload value |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_i | input | 3 | Command code (1 START, 2 repeated START, 3 STOP, 4 receive, 5 acknowledge) |
| ack_bit_i | input | 1 | Level to send for the acknowledge command |
| wr_buf_i | input | 1 | Transmit data write strobe |
| wdata_i | input | 8 | Transmit data |
| wcol_clr_i | input | 1 | Clears the write-collision flag |
| irq_clr_i | input | 1 | Clears the interrupt flag |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe_o | output | 1 | Pull SCL low |
| sda_oe_o | output | 1 | Pull SDA low |
| busy_o | output | 1 | Operation in progress |
| rdata_o | output | 8 | Last received byte |
| ack_stat_o | output | 1 | Acknowledge level sampled after a transmit |
| start_seen_o | output | 1 | START condition last seen |
| stop_seen_o | output | 1 | STOP condition last seen |
| wcol_o | output | 1 | Sticky write-collision flag |
| irq_o | output | 1 | Sticky operation-complete flag |

## Verification
Command acceptance and a transmit-data write can land in the same cycle. The rule is that the command wins and the write counts as a collision. The bench pulses `cmd_valid_i` with the receive code and `wr_buf_i` on the same clock. It then checks three things: exactly eight SCL clocks occur, `rdata_o` holds the byte the bus model sent, and `wcol_o` is set. A separate case writes mid-byte while busy and checks that only the first byte appears on the bus.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  localparam logic [2:0] CMD_START  = 3'd1;
  localparam logic [2:0] CMD_RSTART = 3'd2;
  localparam logic [2:0] CMD_STOP   = 3'd3;
  localparam logic [2:0] CMD_RX     = 3'd4;
  localparam logic [2:0] CMD_ACK    = 3'd5;

  typedef enum logic [3:0] {
    ST_IDLE, ST_RS_A, ST_ST_A, ST_ST_B, ST_ST_C,
    ST_SP_A, ST_SP_B, ST_SP_C, ST_BIT_L, ST_BIT_H
  } seq_st_e;

  typedef enum logic [1:0] {MODE_TX, MODE_RX, MODE_ACK} xfer_mode_e;
endpackage

// File: rtl/i2cm_brg.sv
module i2cm_brg #(
  parameter int CNT_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             hold_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic             tick_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (!run_i)       cnt_q <= reload_i;
    else if (hold_i)       cnt_q <= cnt_q;
    else if (cnt_q == '0)  cnt_q <= reload_i;
    else                   cnt_q <= cnt_q - 1'b1;
  end

  assign tick_o = run_i && !hold_i && (cnt_q == '0);
endmodule

// File: rtl/i2cm_busmon.sv
module i2cm_busmon #(
  parameter int SYNC_N = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s_o,
  output logic sda_s_o,
  output logic start_seen_o,
  output logic stop_seen_o
);
  logic [1:0] raw, syn;
  assign raw = {scl_i, sda_i};

  for (genvar g = 0; g < 2; g++) begin : g_sync
    logic [SYNC_N-1:0] ff_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ff_q <= '1;
      else         ff_q <= {ff_q[SYNC_N-2:0], raw[g]};
    end
    assign syn[g] = ff_q[SYNC_N-1];
  end

  assign scl_s_o = syn[1];
  assign sda_s_o = syn[0];

  logic sda_prev_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sda_prev_q <= 1'b1;
    else         sda_prev_q <= sda_s_o;
  end

  logic start_det, stop_det;
  assign start_det = scl_s_o &&  sda_prev_q && !sda_s_o;
  assign stop_det  = scl_s_o && !sda_prev_q &&  sda_s_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_seen_o <= 1'b0;
      stop_seen_o  <= 1'b0;
    end else if (!en_i) begin
      start_seen_o <= 1'b0;
      stop_seen_o  <= 1'b0;
    end else if (start_det) begin
      start_seen_o <= 1'b1;
      stop_seen_o  <= 1'b0;
    end else if (stop_det) begin
      start_seen_o <= 1'b0;
      stop_seen_o  <= 1'b1;
    end
  end
endmodule

// File: rtl/i2cm_seq.sv
module i2cm_seq
  import i2cm_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          tick_i,
  input  logic          sda_s_i,
  input  logic          bus_free_i,
  input  logic          cmd_valid_i,
  input  logic [2:0]    cmd_i,
  input  logic          ack_bit_i,
  input  logic          wr_buf_i,
  input  logic [DW-1:0] wdata_i,
  output logic          scl_low_o,
  output logic          sda_low_o,
  output logic          busy_o,
  output logic          done_o,
  output logic [DW-1:0] rdata_o,
  output logic          ack_stat_o,
  output logic          wcol_set_o
);
  localparam int CNT_W = $clog2(DW + 1);

  seq_st_e        st_q;
  xfer_mode_e     mode_q;
  logic [CNT_W-1:0] bitn_q;
  logic [DW-1:0]  sr_q;
  logic           park_q, ackb_q;

  logic idle, cmd_ok, cmd_go, wr_ok, last_bit, cur_bit;
  assign idle   = (st_q == ST_IDLE);
  assign busy_o = !idle;

  always_comb begin
    unique case (cmd_i)
      CMD_START:                           cmd_ok = bus_free_i && !park_q;
      CMD_RSTART, CMD_STOP, CMD_RX, CMD_ACK: cmd_ok = park_q;
      default:                             cmd_ok = 1'b0;
    endcase
  end

  assign cmd_go     = en_i && idle && cmd_valid_i && cmd_ok;
  // same-cycle command beats a data write
  assign wr_ok      = en_i && idle && !cmd_valid_i;
  assign wcol_set_o = wr_buf_i && !wr_ok;

  assign last_bit = (mode_q == MODE_ACK) ||
                    (mode_q == MODE_RX && bitn_q == CNT_W'(DW - 1)) ||
                    (mode_q == MODE_TX && bitn_q == CNT_W'(DW));

  always_comb begin
    unique case (mode_q)
      MODE_TX:  cur_bit = (bitn_q == CNT_W'(DW)) ? 1'b1 : sr_q[DW-1];
      MODE_ACK: cur_bit = ackb_q;
      default:  cur_bit = 1'b1;
    endcase
  end

  always_comb begin
    unique case (st_q)
      ST_IDLE:  {scl_low_o, sda_low_o} = {park_q, 1'b0};
      ST_RS_A:  {scl_low_o, sda_low_o} = 2'b10;
      ST_ST_A:  {scl_low_o, sda_low_o} = 2'b00;
      ST_ST_B:  {scl_low_o, sda_low_o} = 2'b01;
      ST_ST_C:  {scl_low_o, sda_low_o} = 2'b11;
      ST_SP_A:  {scl_low_o, sda_low_o} = 2'b11;
      ST_SP_B:  {scl_low_o, sda_low_o} = 2'b01;
      ST_SP_C:  {scl_low_o, sda_low_o} = 2'b00;
      ST_BIT_L: {scl_low_o, sda_low_o} = {1'b1, !cur_bit};
      default:  {scl_low_o, sda_low_o} = {1'b0, !cur_bit};
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE; mode_q <= MODE_TX; bitn_q <= '0; sr_q <= '0;
      park_q <= 1'b0; ackb_q <= 1'b1; done_o <= 1'b0;
      rdata_o <= '0; ack_stat_o <= 1'b0;
    end else if (!en_i) begin
      st_q <= ST_IDLE; park_q <= 1'b0; done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (cmd_go) begin
            bitn_q <= '0;
            unique case (cmd_i)
              CMD_START:  st_q <= ST_ST_A;
              CMD_RSTART: st_q <= ST_RS_A;
              CMD_STOP:   st_q <= ST_SP_A;
              CMD_RX:     begin st_q <= ST_BIT_L; mode_q <= MODE_RX; end
              default:    begin st_q <= ST_BIT_L; mode_q <= MODE_ACK; ackb_q <= ack_bit_i; end
            endcase
          end else if (wr_buf_i && wr_ok) begin
            st_q <= ST_BIT_L; mode_q <= MODE_TX; bitn_q <= '0;
            sr_q <= wdata_i; ack_stat_o <= 1'b0;
          end
        end
        ST_RS_A: if (tick_i) st_q <= ST_ST_A;
        ST_ST_A: if (tick_i) st_q <= ST_ST_B;
        ST_ST_B: if (tick_i) st_q <= ST_ST_C;
        ST_ST_C: if (tick_i) begin st_q <= ST_IDLE; park_q <= 1'b1; done_o <= 1'b1; end
        ST_SP_A: if (tick_i) st_q <= ST_SP_B;
        ST_SP_B: if (tick_i) st_q <= ST_SP_C;
        ST_SP_C: if (tick_i) begin st_q <= ST_IDLE; park_q <= 1'b0; done_o <= 1'b1; end
        ST_BIT_L: if (tick_i) st_q <= ST_BIT_H;
        default: if (tick_i) begin
          if (mode_q == MODE_RX) sr_q <= {sr_q[DW-2:0], sda_s_i};
          if (mode_q == MODE_TX && bitn_q != CNT_W'(DW)) sr_q <= {sr_q[DW-2:0], 1'b0};
          if (mode_q == MODE_TX && bitn_q == CNT_W'(DW)) ack_stat_o <= sda_s_i;
          if (last_bit) begin
            st_q <= ST_IDLE; park_q <= 1'b1; done_o <= 1'b1;
            if (mode_q == MODE_RX) rdata_o <= {sr_q[DW-2:0], sda_s_i};
          end else begin
            st_q <= ST_BIT_L; bitn_q <= bitn_q + 1'b1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/i2c_cmd_master.sv
module i2c_cmd_master #(
  parameter int DW    = 8,
  parameter int BRG_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [BRG_W-1:0] brg_reload_i,
  input  logic             cmd_valid_i,
  input  logic [2:0]       cmd_i,
  input  logic             ack_bit_i,
  input  logic             wr_buf_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic             wcol_clr_i,
  input  logic             irq_clr_i,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             scl_oe_o,
  output logic             sda_oe_o,
  output logic             busy_o,
  output logic [DW-1:0]    rdata_o,
  output logic             ack_stat_o,
  output logic             start_seen_o,
  output logic             stop_seen_o,
  output logic             wcol_o,
  output logic             irq_o
);
  logic scl_s, sda_s, tick, done, wcol_set, scl_low, sda_low, bus_free, hold;

  assign bus_free = stop_seen_o || !start_seen_o;
  // released by us but still low on the wire: stretch
  assign hold     = !scl_low && !scl_s;
  assign scl_oe_o = scl_low;
  assign sda_oe_o = sda_low;

  i2cm_busmon #(.SYNC_N(2)) u_mon (
    .clk_i, .rst_ni, .en_i, .scl_i, .sda_i,
    .scl_s_o(scl_s), .sda_s_o(sda_s),
    .start_seen_o, .stop_seen_o
  );

  i2cm_brg #(.CNT_W(BRG_W)) u_brg (
    .clk_i, .rst_ni, .run_i(busy_o), .hold_i(hold),
    .reload_i(brg_reload_i), .tick_o(tick)
  );

  i2cm_seq #(.DW(DW)) u_seq (
    .clk_i, .rst_ni, .en_i, .tick_i(tick), .sda_s_i(sda_s),
    .bus_free_i(bus_free), .cmd_valid_i, .cmd_i, .ack_bit_i,
    .wr_buf_i, .wdata_i, .scl_low_o(scl_low), .sda_low_o(sda_low),
    .busy_o, .done_o(done), .rdata_o, .ack_stat_o, .wcol_set_o(wcol_set)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wcol_o <= 1'b0;
      irq_o  <= 1'b0;
    end else begin
      if (wcol_set)        wcol_o <= 1'b1;
      else if (wcol_clr_i) wcol_o <= 1'b0;
      if (done)            irq_o <= 1'b1;
      else if (irq_clr_i)  irq_o <= 1'b0;
    end
  end
endmodule

// File: rtl/i2cm_chk.sv
module i2cm_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic en_i,
  input logic wr_buf_i,
  input logic wcol_clr_i,
  input logic irq_clr_i,
  input logic busy_o,
  input logic wcol_o,
  input logic irq_o,
  input logic start_seen_o,
  input logic stop_seen_o
);
  // R9
  busy_write_flags_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && wr_buf_i |=> wcol_o);
  // R9
  wcol_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wcol_o && !wcol_clr_i |=> wcol_o);
  // R9
  irq_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && !irq_clr_i |=> irq_o);
  // R8
  status_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !start_seen_o && !stop_seen_o);
  // R8
  status_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(start_seen_o && stop_seen_o));
  // R2
  idle_when_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !busy_o);
endmodule

bind i2c_cmd_master i2cm_chk u_chk (
  .clk_i, .rst_ni, .en_i, .wr_buf_i, .wcol_clr_i, .irq_clr_i,
  .busy_o, .wcol_o, .irq_o, .start_seen_o, .stop_seen_o
);

// File: tb/tb_i2c_cmd_master.sv
module tb_i2c_cmd_master;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic rst_n = 1'b0, en = 1'b0, cmd_valid = 1'b0, ack_bit = 1'b1;
  logic wr_buf = 1'b0, wcol_clr = 1'b0, irq_clr = 1'b0;
  logic [6:0] reload = 7'd4;
  logic [2:0] cmd = 3'd0;
  logic [7:0] wdata = 8'h00;
  logic scl_oe_o, sda_oe_o, busy_o, ack_stat_o, start_seen_o, stop_seen_o, wcol_o, irq_o;
  logic [7:0] rdata_o;

  logic slv_low = 1'b0, ext_sda_low = 1'b0, ext_scl_low = 1'b0;
  logic scl_line, sda_line;
  assign scl_line = !(scl_oe_o || ext_scl_low);
  assign sda_line = !(sda_oe_o || slv_low || ext_sda_low);

  i2c_cmd_master dut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .brg_reload_i(reload),
    .cmd_valid_i(cmd_valid), .cmd_i(cmd), .ack_bit_i(ack_bit),
    .wr_buf_i(wr_buf), .wdata_i(wdata), .wcol_clr_i(wcol_clr), .irq_clr_i(irq_clr),
    .scl_i(scl_line), .sda_i(sda_line), .scl_oe_o, .sda_oe_o, .busy_o, .rdata_o,
    .ack_stat_o, .start_seen_o, .stop_seen_o, .wcol_o, .irq_o
  );

  int n_chk = 0, n_fail = 0;

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic int exp_low(input logic [6:0] r);
    return int'(r) + 1;
  endfunction

  // bus model: monitor plus slave responder
  int rise_cnt = 0, low_cnt = 0, start_cnt = 0, stop_cnt = 0, stretch_left = 0;
  int low_len [16];
  logic [8:0] mon_sr = '0;
  logic prev_scl = 1'b1, prev_sda = 1'b1, scl_l, sda_l;
  int slv_mode = 0;              // 1 ack responder, 2 byte sender
  logic slv_ack = 1'b0, stretch_req = 1'b0;
  logic [7:0] slv_byte = '0;

  always @(negedge clk) begin
    scl_l = scl_line;
    sda_l = sda_line;
    if (stretch_left > 0) begin
      stretch_left--;
      if (stretch_left == 0) ext_scl_low = 1'b0;
    end
    if (prev_scl && !scl_l) begin
      if (slv_mode == 1) begin
        if (rise_cnt == 8) slv_low = !slv_ack;
        else if (rise_cnt == 9) slv_low = 1'b0;
      end else if (slv_mode == 2) begin
        if (rise_cnt >= 1 && rise_cnt <= 7) slv_low = !slv_byte[7-rise_cnt];
        else if (rise_cnt == 8) slv_low = 1'b0;
      end
      if (stretch_req && rise_cnt == 3) begin
        ext_scl_low = 1'b1; stretch_left = 40; stretch_req = 1'b0;
      end
    end
    if (!prev_scl && scl_l) begin
      mon_sr = {mon_sr[7:0], sda_l};
      rise_cnt++;
      if (rise_cnt < 16) low_len[rise_cnt] = low_cnt;
      low_cnt = 0;
    end else if (!scl_l) low_cnt++;
    if (scl_l && prev_scl && prev_sda && !sda_l) start_cnt++;
    if (scl_l && prev_scl && !prev_sda && sda_l) stop_cnt++;
    prev_scl = scl_l;
    prev_sda = sda_l;
  end

  task automatic mon_reset();
    rise_cnt = 0; mon_sr = '0; low_cnt = 0;
    for (int i = 0; i < 16; i++) low_len[i] = 0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy_o) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic clr_irq();
    @(negedge clk); irq_clr = 1'b1;
    @(negedge clk); irq_clr = 1'b0;
  endtask

  task automatic issue(input logic [2:0] c);
    @(negedge clk); cmd_valid = 1'b1; cmd = c;
    @(negedge clk); cmd_valid = 1'b0;
    while (busy_o) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic do_tx(input logic [7:0] b, input logic ackl);
    clr_irq(); mon_reset();
    slv_mode = 1; slv_ack = ackl;
    @(negedge clk); wr_buf = 1'b1; wdata = b;
    @(negedge clk); wr_buf = 1'b0;
    chk(ack_stat_o == 1'b0, "R3 ack_stat cleared", ack_stat_o, 0);
    wait_idle();
    chk(mon_sr[8:1] == b, "R3 tx byte", mon_sr[8:1], b);
    chk(ack_stat_o == ackl, "R3 ack_stat", ack_stat_o, ackl);
    chk(rise_cnt == 9, "R3 clock count", rise_cnt, 9);
    chk(irq_o, "R3 irq", irq_o, 1);
    chk(low_len[4] == exp_low(reload), "R10 low phase", low_len[4], exp_low(reload));
    slv_mode = 0;
  endtask

  task automatic do_rx(input logic [7:0] b);
    clr_irq(); mon_reset();
    slv_mode = 2; slv_byte = b;
    @(negedge clk); slv_low = !b[7];
    issue(i2cm_pkg::CMD_RX);
    chk(rdata_o == b, "R4 rx byte", rdata_o, b);
    chk(rise_cnt == 8, "R4 clock count", rise_cnt, 8);
    chk(irq_o, "R4 irq", irq_o, 1);
    slv_mode = 0; slv_low = 1'b0;
  endtask

  task automatic do_ack(input logic a);
    clr_irq(); mon_reset();
    @(negedge clk); ack_bit = a;
    issue(i2cm_pkg::CMD_ACK);
    chk(rise_cnt == 1 && mon_sr[0] == a, "R5 ack level", mon_sr[0], a);
    chk(irq_o, "R5 irq", irq_o, 1);
  endtask

  task automatic do_rstart();
    int s0;
    clr_irq(); mon_reset();
    s0 = start_cnt;
    issue(i2cm_pkg::CMD_RSTART);
    chk(start_cnt == s0 + 1, "R7 repeated start seen", start_cnt, s0 + 1);
    chk(scl_oe_o && irq_o, "R7 scl held and irq", {scl_oe_o, irq_o}, 3);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog act=0 exp=1");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    int s0;
    void'($urandom(32'h5eed_1c2a));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!scl_oe_o && !sda_oe_o, "R1 lines released", {scl_oe_o, sda_oe_o}, 0);
    chk(!busy_o && !irq_o && !wcol_o, "R1 flags", {busy_o, irq_o, wcol_o}, 0);
    chk(!start_seen_o && !stop_seen_o, "R1 status", {start_seen_o, stop_seen_o}, 0);

    // R8 external conditions
    en = 1'b1;
    repeat (3) @(negedge clk);
    ext_sda_low = 1'b1;
    repeat (5) @(negedge clk);
    chk(start_seen_o && !stop_seen_o, "R8 start seen", {start_seen_o, stop_seen_o}, 2);
    ext_sda_low = 1'b0;
    repeat (5) @(negedge clk);
    chk(!start_seen_o && stop_seen_o, "R8 stop seen", {start_seen_o, stop_seen_o}, 1);

    // R2 start
    clr_irq();
    s0 = start_cnt;
    issue(i2cm_pkg::CMD_START);
    chk(start_cnt == s0 + 1, "R2 start on bus", start_cnt, s0 + 1);
    chk(scl_oe_o && irq_o, "R2 scl held and irq", {scl_oe_o, irq_o}, 3);
    chk(start_seen_o && !stop_seen_o, "R8 own start", {start_seen_o, stop_seen_o}, 2);

    // R2 ignored while bus taken
    clr_irq();
    @(negedge clk); cmd_valid = 1'b1; cmd = i2cm_pkg::CMD_START;
    @(negedge clk); cmd_valid = 1'b0;
    chk(!busy_o, "R2 ignored busy", busy_o, 0);
    repeat (30) @(negedge clk);
    chk(!irq_o && scl_oe_o, "R2 ignored irq", {irq_o, scl_oe_o}, 1);

    // random mix
    for (int i = 0; i < 28; i++) begin
      int op;
      reload = 7'($urandom_range(2, 9));
      op = $urandom_range(0, 3);
      case (op)
        0: do_tx(8'($urandom), 1'($urandom));
        1: do_rx(8'($urandom));
        2: do_ack(1'($urandom));
        default: do_rstart();
      endcase
    end

    // directed corners
    do_tx(8'h80, 1'b1);
    do_tx(8'h01, 1'b0);
    do_rx(8'hff);
    do_rx(8'h00);

    // R9 write while busy
    clr_irq(); mon_reset();
    slv_mode = 1; slv_ack = 1'b0;
    @(negedge clk); wr_buf = 1'b1; wdata = 8'hA5;
    @(negedge clk); wr_buf = 1'b0;
    repeat (6) @(negedge clk);
    wr_buf = 1'b1; wdata = 8'h3C;
    @(negedge clk); wr_buf = 1'b0;
    chk(wcol_o, "R9 wcol on busy write", wcol_o, 1);
    wait_idle();
    chk(mon_sr[8:1] == 8'hA5 && rise_cnt == 9, "R9 dropped write", mon_sr[8:1], 8'hA5);
    repeat (20) @(negedge clk);
    chk(!busy_o && rise_cnt == 9, "R9 no queued tx", rise_cnt, 9);
    chk(wcol_o, "R9 wcol sticky", wcol_o, 1);
    slv_mode = 0;
    @(negedge clk); wcol_clr = 1'b1;
    @(negedge clk); wcol_clr = 1'b0;
    chk(!wcol_o, "R9 wcol clear", wcol_o, 0);

    // R9 same-cycle command and write
    clr_irq(); mon_reset();
    slv_mode = 2; slv_byte = 8'h6B;
    @(negedge clk); slv_low = !slv_byte[7];
    @(negedge clk); cmd_valid = 1'b1; cmd = i2cm_pkg::CMD_RX; wr_buf = 1'b1; wdata = 8'hEE;
    @(negedge clk); cmd_valid = 1'b0; wr_buf = 1'b0;
    chk(wcol_o, "R9 same-cycle wcol", wcol_o, 1);
    wait_idle();
    chk(rdata_o == 8'h6B && rise_cnt == 8, "R9 command wins", rdata_o, 8'h6B);
    slv_mode = 0; slv_low = 1'b0;
    chk(irq_o, "R9 irq sticky", irq_o, 1);
    repeat (10) @(negedge clk);
    chk(irq_o, "R9 irq held", irq_o, 1);

    // R10 stretching
    clr_irq(); mon_reset();
    reload = 7'd3;
    slv_mode = 2; slv_byte = 8'hC3; stretch_req = 1'b1;
    @(negedge clk); slv_low = !slv_byte[7];
    issue(i2cm_pkg::CMD_RX);
    chk(low_len[4] >= 40, "R10 stretched low", low_len[4], 40);
    chk(rdata_o == 8'hC3, "R10 data after stretch", rdata_o, 8'hC3);
    slv_mode = 0; slv_low = 1'b0;

    // R6 stop
    clr_irq();
    s0 = stop_cnt;
    issue(i2cm_pkg::CMD_STOP);
    chk(stop_cnt == s0 + 1, "R6 stop on bus", stop_cnt, s0 + 1);
    chk(!scl_oe_o && !sda_oe_o && irq_o, "R6 released and irq", {scl_oe_o, sda_oe_o, irq_o}, 1);
    chk(stop_seen_o && !start_seen_o, "R8 own stop", {start_seen_o, stop_seen_o}, 1);

    // R8 disable clears status
    @(negedge clk); en = 1'b0;
    repeat (2) @(negedge clk);
    chk(!start_seen_o && !stop_seen_o && !busy_o, "R8 disable clears", {start_seen_o, stop_seen_o}, 0);

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule